// File: doc/BRIEF.md
# Egress Multi-Queue Priority Scheduler

This block sits on the transmit side of one switch port. It takes packet descriptors from an upstream classifier, each with a 2-bit priority, and holds them in up to four small internal FIFOs. It hands out one descriptor at a time on a dequeue handshake, together with the number of the queue that held it. Frame storage, MAC timing and the classification itself are handled outside this block.

A 2-bit split setting decides how many queues are in use: one, two or four. In two-queue mode a 2-bit threshold sorts priorities into a high queue and a low queue. In four-queue mode the priority selects the queue directly. In that mode the scheduler serves the queues either by strict priority or by weighted fair service. The weighted service uses per-queue 7-bit weights, which reset to 8/4/2/1 for queues 3..0 and can be rewritten one queue at a time.

Top module: `egress_prio_sched`

## Requirements
- R1: Split setting 00 (the reset value) or 11 uses one queue. Every descriptor leaves in arrival order with queue id 0, whatever its priority.
- R2: Split setting 01 uses two queues. A priority at or above `prio_thresh_i` goes to queue 1 and a lower priority goes to queue 0. Queue 1 is always served before queue 0.
- R3: Split setting 10 uses four queues, and queue id equals priority. With `wfq_en_i` = 0, the highest-numbered non-empty queue is served first, so queue 3 is highest and queue 0 lowest.
- R4: `enq_ready_o` is low exactly when the FIFO that the current priority maps to is full (FIFO_DEPTH entries, default 8). An enqueue offered while it is low is dropped.
- R5: `deq_valid_o` is high only when a queue in use holds a descriptor, and `deq_qid_o` always names a queue in use.
- R6: Descriptors within one queue leave in the order they entered.
- R7: With split 10 and `wfq_en_i` = 1, each queue sends at most its weight in descriptors per round. Among queues that still have credit, the highest-numbered goes first. All credits reload to the weights once no backlogged queue has credit left.
- R8: A queue that becomes empty in weighted mode loses the rest of its credit. If it refills, it waits for the next reload.
- R9: Weights reset to 8, 4, 2 and 1 for queues 3, 2, 1 and 0. A cycle with `wgt_we_i[k]` high loads `wgt_i` into the weight of queue k.
- R10: A weight of 0 acts as a weight of 1.
- R11: `wfq_en_i` has no effect unless the split setting is 10. One- and two-queue modes are always strict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| split_mode_i | input | 2 | Queue count: 00/11 one, 01 two, 10 four |
| wfq_en_i | input | 1 | 1 selects weighted service in four-queue mode |
| prio_thresh_i | input | 2 | Two-queue threshold for the high queue |
| wgt_we_i | input | 4 | Per-queue weight write strobes |
| wgt_i | input | WGT_W | Weight value to write |
| enq_valid_i | input | 1 | Enqueue request |
| enq_ready_o | output | 1 | Target FIFO has room |
| enq_desc_i | input | DESC_W | Descriptor to enqueue |
| enq_prio_i | input | 2 | Priority of the descriptor |
| deq_valid_o | output | 1 | A descriptor is offered |
| deq_ready_i | input | 1 | Consumer takes the offered descriptor |
| deq_desc_o | output | DESC_W | Offered descriptor |
| deq_qid_o | output | 2 | Queue the offered descriptor came from |

## Verification
The assertions assume that split setting, threshold, weighted-mode select and weights change only while every queue is empty. Under that assumption, credits never exceed the current weights and the active-queue check stays meaningful. The bench follows this rule: it writes weights and changes configuration only after a full drain. One test stops a drain part way and refills a queue, but leaves the configuration untouched. Push and pop strobes come from the block's own handshakes, so FIFO overflow and underflow checks rely on `enq_ready_o` and `deq_valid_o` being honoured, and the bench only completes handshakes through them.

// File: rtl/eqs_pkg.sv
package eqs_pkg;
  localparam int NQ = 4;
  localparam int QW = 2;

  typedef enum logic [1:0] {
    SPLIT_ONE  = 2'b00,
    SPLIT_TWO  = 2'b01,
    SPLIT_FOUR = 2'b10,
    SPLIT_RSVD = 2'b11
  } split_e;
endpackage

// File: rtl/eqs_fifo.sv
module eqs_fifo #(
  parameter int DW    = 16,
  parameter int DEPTH = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [DW-1:0] data_i,
  input  logic          pop_i,
  output logic [DW-1:0] data_o,
  output logic          empty_o,
  output logic          full_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cnt;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk_i) begin
    if (push_i) mem[wr_ptr] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (push_i) wr_ptr <= nxt(wr_ptr);
      if (pop_i)  rd_ptr <= nxt(rd_ptr);
      case ({push_i, pop_i})
        2'b10:   cnt <= cnt + CW'(1);
        2'b01:   cnt <= cnt - CW'(1);
        default: cnt <= cnt;
      endcase
    end
  end

  assign data_o  = mem[rd_ptr];
  assign empty_o = (cnt == '0);
  assign full_o  = (cnt == CW'(DEPTH));

  a_r4_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o);
  a_r5_no_underflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
  a_r6_count_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !push_i) |=> (cnt == $past(cnt) - CW'(1)));
endmodule

// File: rtl/eqs_map.sv
module eqs_map
  import eqs_pkg::*;
(
  input  logic [1:0]    split_mode_i,
  input  logic [1:0]    prio_thresh_i,
  input  logic [1:0]    prio_i,
  output logic [QW-1:0] qid_o,
  output logic [NQ-1:0] active_o,
  output logic          four_o
);
  always_comb begin
    unique case (split_e'(split_mode_i))
      SPLIT_TWO: begin
        qid_o    = (prio_i >= prio_thresh_i) ? QW'(1) : QW'(0);
        active_o = NQ'(4'b0011);
        four_o   = 1'b0;
      end
      SPLIT_FOUR: begin
        qid_o    = QW'(prio_i);
        active_o = {NQ{1'b1}};
        four_o   = 1'b1;
      end
      default: begin
        qid_o    = '0;
        active_o = NQ'(4'b0001);
        four_o   = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/eqs_sched.sv
module eqs_sched
  import eqs_pkg::*;
#(
  parameter int WW = 7
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [NQ-1:0] nonempty_i,
  input  logic          wfq_i,
  input  logic [NQ-1:0] wgt_we_i,
  input  logic [WW-1:0] wgt_i,
  input  logic          grant_i,
  output logic          valid_o,
  output logic [QW-1:0] sel_o
);
  logic [WW-1:0] wgt_q  [NQ];
  logic [WW-1:0] w_eff  [NQ];
  logic [WW-1:0] cred_q [NQ];
  logic [WW-1:0] eff    [NQ];
  logic [NQ-1:0] has_cred, elig;
  logic          reload;

  for (genvar k = 0; k < NQ; k++) begin : g_q
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         wgt_q[k] <= WW'(1) << k;
      else if (wgt_we_i[k]) wgt_q[k] <= wgt_i;
    end

    assign w_eff[k]    = (wgt_q[k] == '0) ? WW'(1) : wgt_q[k];
    assign has_cred[k] = nonempty_i[k] && (cred_q[k] != '0);
    assign eff[k]      = reload ? w_eff[k] : cred_q[k];
    assign elig[k]     = nonempty_i[k] && (!wfq_i || (eff[k] != '0));

    // empty queues forfeit credit; a grant commits any pending reload
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                         cred_q[k] <= '0;
      else if (!wfq_i || !nonempty_i[k])   cred_q[k] <= '0;
      else if (grant_i)
        cred_q[k] <= eff[k] - ((sel_o == QW'(k)) ? WW'(1) : WW'(0));
    end

    a_r7_cred_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cred_q[k] <= w_eff[k]);
  end

  assign reload  = wfq_i && (has_cred == '0);
  assign valid_o = |nonempty_i;

  always_comb begin
    sel_o = '0;
    for (int k = 0; k < NQ; k++) begin
      if (elig[k]) sel_o = QW'(k);
    end
  end

  a_r3_strict_top: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !wfq_i) |-> ((nonempty_i & ~((NQ'(2) << sel_o) - NQ'(1))) == '0));
  a_r7_sel_backlogged: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> nonempty_i[sel_o]);
endmodule

// File: rtl/egress_prio_sched.sv
module egress_prio_sched
  import eqs_pkg::*;
#(
  parameter int DESC_W     = 16,
  parameter int FIFO_DEPTH = 8,
  parameter int WGT_W      = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        split_mode_i,
  input  logic              wfq_en_i,
  input  logic [1:0]        prio_thresh_i,
  input  logic [NQ-1:0]     wgt_we_i,
  input  logic [WGT_W-1:0]  wgt_i,
  input  logic              enq_valid_i,
  output logic              enq_ready_o,
  input  logic [DESC_W-1:0] enq_desc_i,
  input  logic [1:0]        enq_prio_i,
  output logic              deq_valid_o,
  input  logic              deq_ready_i,
  output logic [DESC_W-1:0] deq_desc_o,
  output logic [QW-1:0]     deq_qid_o
);
  logic [QW-1:0]     tgt_q;
  logic [NQ-1:0]     active, full, empty, push, pop, nonempty;
  logic              four, grant;
  logic [DESC_W-1:0] rd_data [NQ];

  eqs_map u_map (
    .split_mode_i (split_mode_i),
    .prio_thresh_i(prio_thresh_i),
    .prio_i       (enq_prio_i),
    .qid_o        (tgt_q),
    .active_o     (active),
    .four_o       (four)
  );

  assign enq_ready_o = !full[tgt_q];

  for (genvar k = 0; k < NQ; k++) begin : g_fifo
    assign push[k] = enq_valid_i && enq_ready_o && (tgt_q == QW'(k));
    assign pop[k]  = grant && (deq_qid_o == QW'(k));

    eqs_fifo #(.DW(DESC_W), .DEPTH(FIFO_DEPTH)) u_fifo (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .push_i (push[k]),
      .data_i (enq_desc_i),
      .pop_i  (pop[k]),
      .data_o (rd_data[k]),
      .empty_o(empty[k]),
      .full_o (full[k])
    );
  end

  assign nonempty = ~empty & active;
  assign grant    = deq_valid_o && deq_ready_i;

  eqs_sched #(.WW(WGT_W)) u_sched (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .nonempty_i(nonempty),
    .wfq_i     (wfq_en_i && four),
    .wgt_we_i  (wgt_we_i),
    .wgt_i     (wgt_i),
    .grant_i   (grant),
    .valid_o   (deq_valid_o),
    .sel_o     (deq_qid_o)
  );

  assign deq_desc_o = rd_data[deq_qid_o];

  a_r5_qid_active: assert property (@(posedge clk_i) disable iff (!rst_ni)
    deq_valid_o |-> active[deq_qid_o]);
  a_r4_ready_room: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enq_valid_i && enq_ready_o) |=> !empty[$past(tgt_q)]);
endmodule

// File: tb/egress_prio_sched_bench.sv
module egress_prio_sched_bench;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    split_mode = 2'b00;
  logic          wfq_en = 1'b0;
  logic [1:0]    thresh = 2'b00;
  logic [3:0]    wgt_we = '0;
  logic [6:0]    wgt = '0;
  logic          enq_valid = 1'b0;
  logic          enq_ready;
  logic [DW-1:0] enq_desc = '0;
  logic [1:0]    enq_prio = '0;
  logic          deq_valid;
  logic          deq_ready = 1'b0;
  logic [DW-1:0] deq_desc;
  logic [1:0]    deq_qid;

  always #4 clk = ~clk;

  egress_prio_sched u_egress_prio_sched (
    .clk_i(clk), .rst_ni(rst_n), .split_mode_i(split_mode), .wfq_en_i(wfq_en),
    .prio_thresh_i(thresh), .wgt_we_i(wgt_we), .wgt_i(wgt),
    .enq_valid_i(enq_valid), .enq_ready_o(enq_ready), .enq_desc_i(enq_desc),
    .enq_prio_i(enq_prio), .deq_valid_o(deq_valid), .deq_ready_i(deq_ready),
    .deq_desc_o(deq_desc), .deq_qid_o(deq_qid)
  );

  int            n_cmp = 0;
  int            n_bad = 0;
  string         cur_req = "R0";
  int            exp_qid [$];
  logic [DW-1:0] mdl [4][$];
  logic [DW-1:0] tag = 16'h0100;

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  task automatic check(input string req, input int act, input int exp, input string what);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && deq_valid && deq_ready) begin
      n_cmp++;
      if (exp_qid.size() == 0) begin
        n_bad++;
        $display("FAIL %s unexpected output: actual qid=%0d desc=%h expected none",
                 cur_req, deq_qid, deq_desc);
      end else begin
        int eq;
        logic [DW-1:0] ed;
        eq = exp_qid.pop_front();
        ed = (mdl[eq].size() > 0) ? mdl[eq].pop_front() : '0;
        if (deq_qid !== eq[1:0] || deq_desc !== ed) begin
          n_bad++;
          $display("FAIL %s dequeue: actual qid=%0d desc=%h expected qid=%0d desc=%h",
                   cur_req, deq_qid, deq_desc, eq, ed);
        end
      end
    end
  end

  task automatic enq(input logic [1:0] prio, input int q, input bit acc);
    @(posedge clk); #1;
    enq_valid = 1'b1;
    enq_desc  = tag;
    enq_prio  = prio;
    @(negedge clk);
    check(cur_req, int'(enq_ready), int'(acc), "enq_ready");
    if (acc) mdl[q].push_back(tag);
    tag = tag + 16'd1;
    @(posedge clk); #1;
    enq_valid = 1'b0;
  endtask

  task automatic enq_n(input logic [1:0] prio, input int q, input int n);
    for (int i = 0; i < n; i++) enq(prio, q, 1'b1);
  endtask

  task automatic expect_q(input int q, input int n);
    for (int i = 0; i < n; i++) exp_qid.push_back(q);
  endtask

  task automatic drain(input bit chk_idle);
    int guard = 0;
    @(posedge clk); #1;
    deq_ready = 1'b1;
    while (exp_qid.size() != 0 && guard < 2000) begin
      @(posedge clk); #1;
      guard++;
    end
    deq_ready = 1'b0;
    if (guard >= 2000) begin
      n_cmp++;
      n_bad++;
      $display("FAIL %s drain: actual %0d items pending expected 0", cur_req, exp_qid.size());
      exp_qid.delete();
    end
    if (chk_idle) begin
      @(negedge clk);
      check("R5", int'(deq_valid), 0, "deq_valid after drain");
    end
  endtask

  task automatic wr_wgt(input int q, input logic [6:0] v);
    @(posedge clk); #1;
    wgt_we = 4'(1 << q);
    wgt    = v;
    @(posedge clk); #1;
    wgt_we = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check("R5", int'(deq_valid), 0, "deq_valid at reset");
    check("R4", int'(enq_ready), 1, "enq_ready at reset");

    // R1 R6: single queue, arrival order regardless of priority
    cur_req = "R1/R6";
    enq(2'd3, 0, 1); enq(2'd0, 0, 1); enq(2'd2, 0, 1); enq(2'd1, 0, 1);
    expect_q(0, 4);
    drain(1);
    split_mode = 2'b11;
    cur_req = "R1 mode 11";
    enq(2'd1, 0, 1); enq(2'd3, 0, 1);
    expect_q(0, 2);
    drain(1);

    // R4: fill queue, extra enqueue dropped
    split_mode = 2'b00;
    cur_req = "R4";
    for (int i = 0; i < 8; i++) enq(2'(i), 0, 1);
    enq(2'd2, 0, 0);
    expect_q(0, 8);
    drain(1);

    // R2 R11: two queues, threshold 2, wfq_en ignored
    split_mode = 2'b01; thresh = 2'd2; wfq_en = 1'b1;
    cur_req = "R2/R11";
    enq(2'd0, 0, 1); enq(2'd1, 0, 1); enq(2'd2, 1, 1);
    enq(2'd3, 1, 1); enq(2'd0, 0, 1); enq(2'd3, 1, 1);
    expect_q(1, 3); expect_q(0, 3);
    drain(1);
    thresh = 2'd0;
    cur_req = "R2 thresh 0";
    enq(2'd0, 1, 1); enq(2'd3, 1, 1);
    expect_q(1, 2);
    drain(1);
    thresh = 2'd3;
    cur_req = "R2 thresh 3";
    enq(2'd2, 0, 1); enq(2'd3, 1, 1);
    expect_q(1, 1); expect_q(0, 1);
    drain(1);

    // R3: four queues strict
    split_mode = 2'b10; wfq_en = 1'b0;
    cur_req = "R3";
    enq(2'd0, 0, 1); enq(2'd1, 1, 1); enq(2'd2, 2, 1);
    enq(2'd3, 3, 1); enq(2'd1, 1, 1); enq(2'd3, 3, 1);
    expect_q(3, 2); expect_q(2, 1); expect_q(1, 2); expect_q(0, 1);
    drain(1);

    // R9 R7: reset weights 8/4/2/1
    wfq_en = 1'b1;
    cur_req = "R7/R9";
    enq_n(2'd3, 3, 8); enq_n(2'd2, 2, 4); enq_n(2'd1, 1, 2); enq_n(2'd0, 0, 2);
    expect_q(3, 8); expect_q(2, 4); expect_q(1, 2); expect_q(0, 2);
    drain(1);

    // R10 R7: weights 2/1/0/1
    wr_wgt(3, 7'd2); wr_wgt(2, 7'd1); wr_wgt(1, 7'd0); wr_wgt(0, 7'd1);
    cur_req = "R7/R10";
    enq_n(2'd3, 3, 4); enq_n(2'd2, 2, 4); enq_n(2'd1, 1, 4); enq_n(2'd0, 0, 4);
    for (int r = 0; r < 2; r++) begin
      expect_q(3, 2); expect_q(2, 1); expect_q(1, 1); expect_q(0, 1);
    end
    for (int r = 0; r < 2; r++) begin
      expect_q(2, 1); expect_q(1, 1); expect_q(0, 1);
    end
    drain(1);

    // R8: queue that empties forfeits credit
    wr_wgt(3, 7'd3); wr_wgt(2, 7'd2);
    cur_req = "R8";
    enq_n(2'd3, 3, 1); enq_n(2'd2, 2, 3);
    expect_q(3, 1);
    drain(0);
    enq_n(2'd3, 3, 2);
    expect_q(2, 2); expect_q(3, 2); expect_q(2, 1);
    drain(1);

    finish_run();
  end
endmodule